// File: doc/BRIEF.md
# Ping-Pong Receive Buffer Controller

This block sits between up to eight receive channels and a host. It has two equal message stores that trade roles. At any time the host owns one store and reads it. The other store takes in whatever the channels deliver. A fixed-priority arbiter picks one channel message per cycle and appends it to the collecting store at that store's fill position.

When the host has finished with its store, it issues a release with one command write. The store it gave back is emptied and becomes the collecting store. The store that was collecting is handed to the host. If the new host store already holds messages, an interrupt pulse goes out at once. If it is empty, it stays open for writes. The first message that lands in it closes it and raises the pulse. After that, traffic flows to the other store again.

Every pulse sets a per-store status bit. A store that is full drops further messages and sets a sticky overflow bit. The host clears status bits by writing ones to them. A second command bit releases both stores at once and discards everything held in them.

Top module: `pp_rx_buffer_ctrl`

## Requirements
- R1: After reset, the host owns store 0 and `host_buf` is 0. `host_count`, `status` and `irq` are all 0. Store 0 is open, so the first stored message goes into it.
- R2: When several channels are valid in the same cycle, the lowest-numbered one wins. `ch_grant` is one-hot on the winner, or zero when no channel is valid. At most one message is taken per cycle.
- R3: While the host store is closed, each taken message is written into the other store at index equal to that store's count, and that count goes up by one. `host_count` always shows the count of the host store.
- R4: A write to `cmd_wr` with `cmd_data[0]`=1 and `cmd_data[1]`=0, while the host store is closed, swaps the roles at that clock edge. If the new host store is non-empty, `irq` is high for the next cycle.
- R5: If the store handed over by a release is empty, no pulse is given and that store is open. The first message taken is written into it at index 0. `irq` pulses in the following cycle and the store closes, so later messages go to the other store.
- R6: `irq` lasts one cycle per event. In the same cycle it is high, `status` bit 0 (store 0) or bit 1 (store 1) is set for the store that caused it.
- R7: When `stat_wr` is high, each `status` bit whose `stat_data` bit is 1 is cleared, and bits written with 0 keep their value. A bit being set in the same cycle stays set.
- R8: A message that arrives while its target store already holds `DEPTH` messages is dropped. The count stays at `DEPTH`, stored data is not changed, and `status` bit 2 (overflow) is set and stays set until it is cleared.
- R9: A single release issued while the host store is still open has no effect on `host_buf`, on the counts or on `irq`.
- R10: A write with `cmd_data[1]`=1 empties both stores, flips `host_buf` and leaves the new host store open without a pulse, whatever `cmd_data[0]` holds. A message presented in that cycle is discarded without setting overflow.
- R11: A released store restarts at count 0, so the next message it collects is written at index 0.
- R12: With `rd_en` high, `rd_data` shows the word at `rd_addr` in the host store one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | NCH | Per-channel message present |
| ch_data | input | NCH*DW | Per-channel message word, channel c at bits [c*DW +: DW] |
| ch_grant | output | NCH | One-hot: channel whose message is taken this cycle |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | $clog2(DEPTH) | Word index inside the host store |
| rd_data | output | DW | Read word, one cycle after `rd_en` |
| host_buf | output | 1 | Index of the store the host owns |
| host_count | output | $clog2(DEPTH+1) | Message count of the host store |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 2 | Bit 0 releases the host store, bit 1 releases both |
| stat_wr | input | 1 | Status write strobe |
| stat_data | input | 3 | Ones clear the matching status bits |
| status | output | 3 | Bit 0 store-0 event, bit 1 store-1 event, bit 2 overflow |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench exercises these corner cases:
- **Release into an empty store.** A design that pulsed at the release, or never pulsed, would lose the edge the host waits on. The bench checks for silence at the release and a single pulse on the first arrival.
- **Release while the host store is still open.** A design that swapped here would hand the host an unannounced store.
- **Overflow.** The bench fills a store to its limit and sends one more message. It then reads the last word back, which catches a design that overwrote stored data or let the count pass `DEPTH`.
- **Clear against set.** A status clear is issued in the same cycle an event sets that bit. A design where the clear wins would lose the event.
- **Arbitration.** Messages from several channels at once check the lowest-index-wins rule.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;
  // status register bit positions
  localparam int STAT_B0  = 0;
  localparam int STAT_B1  = 1;
  localparam int STAT_OVF = 2;
  localparam int STAT_W   = 3;

  // command register bit positions
  localparam int CMD_REL     = 0;
  localparam int CMD_REL_ALL = 1;
  localparam int CMD_W       = 2;

  typedef struct packed {
    logic rel_all;
    logic rel_one;
  } cmd_dec_t;

  // decode one command write; release-all dominates
  function automatic cmd_dec_t decode_cmd(input logic wr, input logic [CMD_W-1:0] d,
                                          input logic open_now);
    cmd_dec_t r;
    r.rel_all = wr & d[CMD_REL_ALL];
    r.rel_one = wr & d[CMD_REL] & ~d[CMD_REL_ALL] & ~open_now;
    return r;
  endfunction

  // write-one-to-clear update with set priority
  function automatic logic [STAT_W-1:0] w1c_update(input logic [STAT_W-1:0] cur,
                                                   input logic [STAT_W-1:0] clr,
                                                   input logic [STAT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/pp_rx_arbiter.sv
module pp_rx_arbiter #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input  logic [NCH-1:0]    req,
  input  logic [NCH*DW-1:0] req_data,
  output logic [NCH-1:0]    grant,
  output logic              win_valid,
  output logic [DW-1:0]     win_data
);
  // fixed priority: lowest index wins
  for (genvar i = 0; i < NCH; i++) begin : g_pri
    if (i == 0) begin : g_first
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign win_valid = |req;

  always_comb begin
    win_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (grant[c]) win_data = win_data | req_data[c*DW +: DW];
    end
  end
endmodule

// File: rtl/pp_rx_bufmem.sv
module pp_rx_bufmem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wbuf,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic          rbuf,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  // both stores in one array, store index is the address MSB (DEPTH must be a power of two)
  localparam int WORDS = 2 * DEPTH;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[{wbuf, widx}] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (re) rdata <= mem[{rbuf, ridx}];
  end
endmodule

// File: rtl/pp_rx_own_ctrl.sv
module pp_rx_own_ctrl
  import pp_rx_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_data,
  output logic              host_buf,
  output logic              host_open,
  output logic [CW-1:0]     host_count,
  output logic              wr_fire,
  output logic              wr_buf,
  output logic [AW-1:0]     wr_idx,
  output logic              drop_fire,
  output logic              irq,
  output logic [STAT_W-1:0] status
);
  function automatic logic at_cap(input logic [CW-1:0] c);
    return c == CW'(DEPTH);
  endfunction

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  logic [1:0][CW-1:0] cnt, cnt_n;
  logic               hb_n, open_n, fire, fire_buf, col_buf;
  logic [CW-1:0]      tgt_cnt;
  logic [STAT_W-1:0]  set_bits, clr_bits;
  cmd_dec_t           cmd;

  assign col_buf    = ~host_buf;
  assign wr_buf     = host_open ? host_buf : col_buf;
  assign tgt_cnt    = cnt[wr_buf];
  assign wr_idx     = tgt_cnt[AW-1:0];
  assign cmd        = decode_cmd(cmd_wr, cmd_data, host_open);
  assign wr_fire    = win_valid & ~at_cap(tgt_cnt) & ~cmd.rel_all;
  assign drop_fire  = win_valid &  at_cap(tgt_cnt) & ~cmd.rel_all;
  assign host_count = cnt[host_buf];

  always_comb begin
    cnt_n    = cnt;
    hb_n     = host_buf;
    open_n   = host_open;
    fire     = 1'b0;
    fire_buf = host_buf;
    if (wr_fire) cnt_n[wr_buf] = bump(tgt_cnt);
    if (cmd.rel_all) begin
      cnt_n  = '0;
      hb_n   = col_buf;
      open_n = 1'b1;
    end else if (cmd.rel_one) begin
      cnt_n[host_buf] = '0;
      hb_n            = col_buf;
      if (cnt_n[col_buf] == '0) begin
        open_n = 1'b1;
      end else begin
        fire     = 1'b1;
        fire_buf = col_buf;
      end
    end else if (host_open && wr_fire) begin
      open_n = 1'b0;
      fire   = 1'b1;
    end
  end

  always_comb begin
    set_bits = '0;
    if (fire) set_bits[fire_buf ? STAT_B1 : STAT_B0] = 1'b1;
    if (drop_fire) set_bits[STAT_OVF] = 1'b1;
    clr_bits = stat_wr ? stat_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      host_buf  <= 1'b0;
      host_open <= 1'b1;
      irq       <= 1'b0;
      status    <= '0;
    end else begin
      cnt       <= cnt_n;
      host_buf  <= hb_n;
      host_open <= open_n;
      irq       <= fire;
      status    <= w1c_update(status, clr_bits, set_bits);
    end
  end
endmodule

// File: rtl/pp_rx_buffer_ctrl.sv
module pp_rx_buffer_ctrl
  import pp_rx_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH*DW-1:0] ch_data,
  output logic [NCH-1:0]    ch_grant,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              host_buf,
  output logic [CW-1:0]     host_count,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  // named internal events, also observed by the checker
  logic          win_valid;
  logic [DW-1:0] win_data;
  logic          host_open;
  logic          wr_fire;
  logic          wr_buf;
  logic [AW-1:0] wr_idx;
  logic          drop_fire;

  pp_rx_arbiter #(.NCH(NCH), .DW(DW)) u_arb (
    .req      (ch_valid),
    .req_data (ch_data),
    .grant    (ch_grant),
    .win_valid(win_valid),
    .win_data (win_data)
  );

  pp_rx_own_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .stat_wr   (stat_wr),
    .stat_data (stat_data),
    .host_buf  (host_buf),
    .host_open (host_open),
    .host_count(host_count),
    .wr_fire   (wr_fire),
    .wr_buf    (wr_buf),
    .wr_idx    (wr_idx),
    .drop_fire (drop_fire),
    .irq       (irq),
    .status    (status)
  );

  pp_rx_bufmem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_fire),
    .wbuf (wr_buf),
    .widx (wr_idx),
    .wdata(win_data),
    .re   (rd_en),
    .rbuf (host_buf),
    .ridx (rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/pp_rx_checker.sv
module pp_rx_checker #(
  parameter int NCH   = 8,
  parameter int DEPTH = 1024,
  parameter int CW    = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_valid,
  input logic [NCH-1:0] ch_grant,
  input logic           host_buf,
  input logic           host_open,
  input logic [CW-1:0]  host_count,
  input logic           cmd_wr,
  input logic [1:0]     cmd_data,
  input logic           stat_wr,
  input logic [2:0]     stat_data,
  input logic [2:0]     status,
  input logic           wr_fire,
  input logic           drop_fire,
  input logic           irq
);
  // R2
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_grant) && ((ch_grant & ~ch_valid) == '0));
  a_r2_grant_any: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_valid) == (|ch_grant));
  // R4
  a_r4_release_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_data == 2'b01 && !host_open) |=> (host_buf != $past(host_buf)));
  // R5
  a_r5_open_first_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (host_open && wr_fire && !cmd_wr) |=> (irq && !host_open));
  // R6
  a_r6_irq_marks_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[host_buf] && !host_open));
  // R7
  a_r7_w1c_keeps_zero_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_data[2] && status[2]) |=> status[2]);
  // R8
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    host_count <= CW'(DEPTH));
  a_r8_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fire |=> status[2]);
  // R9
  a_r9_open_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_data == 2'b01 && host_open) |=> ($stable(host_buf) && !irq));
  // R10
  a_r10_release_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_data[1]) |=> (host_open && host_count == '0 && !irq));
endmodule

bind pp_rx_buffer_ctrl pp_rx_checker #(.NCH(NCH), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_valid  (ch_valid),
  .ch_grant  (ch_grant),
  .host_buf  (host_buf),
  .host_open (host_open),
  .host_count(host_count),
  .cmd_wr    (cmd_wr),
  .cmd_data  (cmd_data),
  .stat_wr   (stat_wr),
  .stat_data (stat_data),
  .status    (status),
  .wr_fire   (wr_fire),
  .drop_fire (drop_fire),
  .irq       (irq)
);

// File: tb/tb_pp_rx_buffer_ctrl.sv
module tb_pp_rx_buffer_ctrl;
  localparam int NCH   = 8;
  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  // vector: kind[22:21] (0 msg,1 cmd,2 clr), arg[20:13], exp host_buf[12],
  //         exp irq[11], exp status[10:8], exp host_count[7:0]
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 8'h04, 1'b0, 1'b1, 3'b001, 8'd1},  // R5 R1: first msg into open store 0
    {2'd0, 8'h0A, 1'b0, 1'b0, 3'b001, 8'd1},  // R2 R3: ch1 wins, into store 1
    {2'd0, 8'h80, 1'b0, 1'b0, 3'b001, 8'd1},  // R3
    {2'd2, 8'h01, 1'b0, 1'b0, 3'b000, 8'd1},  // R7 clear bit0
    {2'd1, 8'h01, 1'b1, 1'b1, 3'b010, 8'd2},  // R4 swap with data
    {2'd0, 8'hFF, 1'b1, 1'b0, 3'b010, 8'd2},  // R2 R11: ch0 into store 0
    {2'd1, 8'h01, 1'b0, 1'b1, 3'b011, 8'd1},  // R4 R6
    {2'd1, 8'h01, 1'b1, 1'b0, 3'b011, 8'd0},  // R5: empty store handed over
    {2'd1, 8'h01, 1'b1, 1'b0, 3'b011, 8'd0},  // R9: release while open ignored
    {2'd0, 8'h10, 1'b1, 1'b1, 3'b011, 8'd1},  // R5: first arrival closes
    {2'd0, 8'h20, 1'b1, 1'b0, 3'b011, 8'd1},  // R5: next goes elsewhere
    {2'd2, 8'h07, 1'b1, 1'b0, 3'b000, 8'd1},  // R7
    {2'd1, 8'h03, 1'b0, 1'b0, 3'b000, 8'd0},  // R10
    {2'd0, 8'h01, 1'b0, 1'b1, 3'b001, 8'd1}   // R10 R11
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    ch_valid;
  logic [NCH*DW-1:0] ch_data;
  logic [NCH-1:0]    ch_grant;
  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic [DW-1:0]     rd_data;
  logic              host_buf;
  logic [CW-1:0]     host_count;
  logic              cmd_wr;
  logic [1:0]        cmd_data;
  logic              stat_wr;
  logic [2:0]        stat_data;
  logic [2:0]        status;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pp_rx_buffer_ctrl #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  function automatic logic [DW-1:0] word_of(input int ch, input int tag);
    return {8'(ch), 8'hB0, 16'(tag)};
  endfunction

  function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] m);
    for (int k = 0; k < NCH; k++) if (m[k]) return NCH'(1) << k;
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ch_valid = '0; cmd_wr = 1'b0; cmd_data = '0;
    stat_wr = 1'b0; stat_data = '0; rd_en = 1'b0;
  endtask

  task automatic put(input logic [NCH-1:0] m, input int tag);
    for (int c = 0; c < NCH; c++) ch_data[c*DW +: DW] = word_of(c, tag);
    ch_valid = m;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic read_chk(input string req, input int idx, input logic [DW-1:0] exp);
    rd_en = 1'b1; rd_addr = AW'(idx);
    step();
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(); ch_data = '0; rd_addr = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 host_buf", 32'(host_buf), 0);
    check("R1 host_count", 32'(host_count), 0);
    check("R1 status", 32'(status), 0);
    check("R1 irq", 32'(irq), 0);
    check("R2 idle grant", 32'(ch_grant), 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      case (v[22:21])
        2'd0: put(v[20:13], i);
        2'd1: begin cmd_wr = 1'b1; cmd_data = v[14:13]; end
        default: begin stat_wr = 1'b1; stat_data = v[15:13]; end
      endcase
      #1;
      if (v[22:21] == 2'd0) check($sformatf("R2 grant v%0d", i), 32'(ch_grant), 32'(lowest(v[20:13])));
      step();
      check($sformatf("R4 host_buf v%0d", i), 32'(host_buf), 32'(v[12]));
      check($sformatf("R6 irq v%0d", i), 32'(irq), 32'(v[11]));
      check($sformatf("R7 status v%0d", i), 32'(status), 32'(v[10:8]));
      check($sformatf("R3 host_count v%0d", i), 32'(host_count), 32'(v[7:0]));
    end

    // R12 R11: store 0 index 0 holds ch0 word of vector 13
    read_chk("R12 read after release-all", 0, word_of(0, 13));

    // R8: fill store 1, then one extra
    for (int k = 0; k <= DEPTH; k++) begin
      put(8'h20, 100 + k);
      step();
    end
    check("R8 overflow bit", 32'(status), 32'b101);
    cmd_wr = 1'b1; cmd_data = 2'b01;
    step();
    check("R8 count capped", 32'(host_count), DEPTH);
    check("R4 irq after full swap", 32'(irq), 1);
    check("R6 status", 32'(status), 32'b111);
    read_chk("R8 last word kept", DEPTH - 1, word_of(5, 100 + DEPTH - 1));
    read_chk("R3 first word", 0, word_of(5, 100));

    // R7 set beats clear
    stat_wr = 1'b1; stat_data = 3'b111;
    step();
    check("R7 clear all", 32'(status), 0);
    cmd_wr = 1'b1; cmd_data = 2'b01;
    step();
    check("R5 empty handover no irq", 32'(irq), 0);
    check("R11 host store emptied", 32'(host_count), 0);
    put(8'h08, 200); stat_wr = 1'b1; stat_data = 3'b001;
    step();
    check("R7 set wins over clear", 32'(status), 32'b001);
    check("R5 irq on first arrival", 32'(irq), 1);
    step();
    check("R6 irq single cycle", 32'(irq), 0);
    read_chk("R5 open store index 0", 0, word_of(3, 200));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule